// File: doc/BRIEF.md
# SPI Register Memory with DAC Code Register

This block is a serial peripheral slave that gives access to a 64-byte, byte-addressed store. The lower 56 bytes form a free general-purpose area. The top 8 bytes form a control area. Two of those control bytes hold the 12-bit code that a digital-to-analog converter would use. Some control locations are reserved, and some bits inside the control bytes are reserved and always read as zero. Several control bytes load fixed values at reset.

Every SPI pin is sampled in the system clock domain through a synchronizer, and SCK edges are found by comparing successive samples. Each transaction starts when chip select falls. It carries a command byte, an address byte and then data bytes. Read data is fetched ahead, one byte before it is needed. Write data is collected in a one-page buffer and is committed to the store after chip select rises. An active-low shift enable input can stall input shifting at any point.

Top module: `spi_regmem`

## Requirements
- R1: After reset, control bytes 38h, 39h, 3Ah, 3Bh, 3Dh, 3Eh and 3Fh read 00h and 3Ch reads 84h. `dac_code` is 000h and `sdo` is 0.
- R2: A bit is taken from `sdi` on a rising edge of `sck` only while `cs_n` is low and `shift_en_n` is low. A rising edge while `shift_en_n` is high is ignored. Every byte is shifted MSB first.
- R3: `sdo` changes only after a falling edge of `sck` that follows an accepted rising edge. `sdo` is 0 while `cs_n` is high.
- R4: The first byte after `cs_n` falls is the command: 02h writes and 03h reads. The second byte is the address, and only its low 6 bits are used. Any other command byte is ignored until `cs_n` rises: nothing is written and `sdo` stays 0.
- R5: A read returns the byte at the address, then the following bytes, with the address increasing by one each time and wrapping from 3Fh to 00h. The first data bit appears on the falling edge that ends the address byte.
- R6: Write data bytes go to successive addresses inside the 8-byte page of the start address. Bits 5:3 of the address stay fixed and bits 2:0 wrap. A later byte to the same location overwrites an earlier one. The store changes only after `cs_n` rises.
- R7: When `cs_n` rises in the middle of a byte, that partial byte is discarded and the complete bytes before it are still written.
- R8: Writes to the reserved locations 3Ah, 3Bh, 3Eh and 3Fh are ignored. These locations read 00h.
- R9: Bits 3:0 of 39h and of 3Dh are reserved. They are stored as 0 whatever is written to them.
- R10: `dac_code` equals {byte 38h, bits 7:4 of byte 39h}. Code 000h is zero scale and FFFh is full scale. It follows a write to those bytes once the write is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data into the block |
| shift_en_n | input | 1 | Active-low enable for input shifting |
| sdo | output | 1 | Serial data out of the block |
| dac_code | output | 12 | Converter code from bytes 38h and 39h |

## Verification
The bench builds the block with its default sizes: 6 address bits, 8-byte pages and a two-stage synchronizer. With these sizes the control area sits at 38h to 3Fh. A read burst longer than 64 bytes can pass the 3Fh to 00h wrap, and a 10-byte write is enough to wrap a page and overwrite its own first bytes. The SCK half period is six system clocks, which leaves room for the synchronizer delay and the one-byte read prefetch. Random bursts that land in the control page exercise the reserved-location and reserved-bit masks together with the converter code.

// File: rtl/spi_regmem_pkg.sv
package spi_regmem_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam int CTRL_W = 3;
  localparam int CTRL_N = 1 << CTRL_W;
  localparam int DAC_W  = 12;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_WRITE, PH_READ, PH_SKIP} phase_t;

  // Writable bits of each control byte; zero bits are reserved.
  function automatic logic [7:0] ctrl_mask(input logic [CTRL_W-1:0] idx);
    case (idx)
      3'd0, 3'd4: ctrl_mask = 8'hFF;
      3'd1, 3'd5: ctrl_mask = 8'hF0;
      default:    ctrl_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_reset(input logic [CTRL_W-1:0] idx);
    ctrl_reset = (idx == 3'd4) ? 8'h84 : 8'h00;
  endfunction
endpackage

// File: rtl/spi_regmem_link.sv
module spi_regmem_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic       shift_en_n,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sdo
);
  logic [SYNC_STAGES-1:0] cs_sr, sck_sr, sdi_sr, en_sr;
  logic cs_s, sck_s, sdi_s, hold_s, cs_q, sck_q, armed, take;
  logic [2:0] bit_cnt;
  logic [7:0] txr;

  assign cs_s    = cs_sr[SYNC_STAGES-1];
  assign sck_s   = sck_sr[SYNC_STAGES-1];
  assign sdi_s   = sdi_sr[SYNC_STAGES-1];
  assign hold_s  = en_sr[SYNC_STAGES-1];
  assign take    = sck_s & ~sck_q & ~cs_s & ~hold_s;
  assign cs_fall = ~cs_s & cs_q;
  assign cs_rise = cs_s & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sr  <= '1;
      sck_sr <= '0;
      sdi_sr <= '0;
      en_sr  <= '1;
    end else begin
      cs_sr  <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sck_sr <= {sck_sr[SYNC_STAGES-2:0], sck};
      sdi_sr <= {sdi_sr[SYNC_STAGES-2:0], sdi};
      en_sr  <= {en_sr[SYNC_STAGES-2:0], shift_en_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      sck_q <= 1'b0;
      bit_cnt <= '0;
      rx_byte <= '0;
      byte_done <= 1'b0;
      armed <= 1'b0;
      txr <= '0;
      sdo <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sck_q <= sck_s;
      byte_done <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        armed <= 1'b0;
        txr <= '0;
        sdo <= 1'b0;
      end else begin
        if (take) begin
          rx_byte <= {rx_byte[6:0], sdi_s};
          bit_cnt <= bit_cnt + 3'd1;
          armed <= 1'b1;
          byte_done <= (bit_cnt == 3'd7);
        end
        if (tx_load) begin
          txr <= tx_byte;
        end else if (~sck_s && sck_q && armed) begin
          sdo <= txr[7];
          txr <= {txr[6:0], 1'b0};
          armed <= 1'b0;
        end
      end
    end
  end

  assert_sdo_idle_R3: assert property (@(posedge clk) disable iff (rst) cs_s |=> !sdo);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst) !take |=> $stable(rx_byte));
endmodule

// File: rtl/spi_regmem_ctrl.sv
module spi_regmem_ctrl
  import spi_regmem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        rd_data,
  output logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int PAGE_N = 1 << PAGE_W;

  phase_t phase;
  logic op_wr, committing;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] slot, cidx;
  logic [PAGE_N-1:0] pvalid;
  logic [7:0] pbuf [PAGE_N];
  logic edge_free;

  assign edge_free = ~cs_fall & ~cs_rise;
  assign rd_en   = edge_free & byte_done &
                   ((phase == PH_ADDR && !op_wr) || phase == PH_READ);
  assign rd_addr = (phase == PH_ADDR) ? rx_byte[ADDR_W-1:0] : ptr;
  assign tx_byte = rd_data;
  assign wr_en   = committing & pvalid[cidx];
  assign wr_addr = {page_q, cidx};
  assign wr_data = pbuf[cidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD;
      op_wr <= 1'b0;
      ptr <= '0;
      page_q <= '0;
      slot <= '0;
      pvalid <= '0;
      committing <= 1'b0;
      cidx <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= rd_en;
      if (committing) begin
        cidx <= cidx + 1'b1;
        if (cidx == PAGE_W'(PAGE_N - 1)) committing <= 1'b0;
      end
      if (cs_fall) begin
        phase <= PH_CMD;
        pvalid <= '0;
      end else if (cs_rise) begin
        if (phase == PH_WRITE && |pvalid) begin
          committing <= 1'b1;
          cidx <= '0;
        end
        phase <= PH_CMD;
      end else if (byte_done) begin
        case (phase)
          PH_CMD: begin
            op_wr <= (rx_byte == OP_WRITE);
            phase <= (rx_byte == OP_WRITE || rx_byte == OP_READ) ? PH_ADDR : PH_SKIP;
          end
          PH_ADDR: begin
            page_q <= rx_byte[ADDR_W-1:PAGE_W];
            slot <= rx_byte[PAGE_W-1:0];
            pvalid <= '0;
            ptr <= rx_byte[ADDR_W-1:0] + ADDR_W'(1);
            phase <= op_wr ? PH_WRITE : PH_READ;
          end
          PH_WRITE: begin
            pbuf[slot] <= rx_byte;
            pvalid[slot] <= 1'b1;
            slot <= slot + 1'b1;
          end
          PH_READ: ptr <= ptr + ADDR_W'(1);
          default: ;
        endcase
      end
    end
  end

  assert_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP && edge_free) |=> phase == PH_SKIP);
  assert_commit_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (phase == PH_CMD || phase == PH_SKIP || phase == PH_ADDR));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_done && edge_free && phase == PH_READ && ptr == '1) |=> ptr == '0);
endmodule

// File: rtl/spi_regmem_store.sv
module spi_regmem_store
  import spi_regmem_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [DAC_W-1:0]  dac_code
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int GP_N  = DEPTH - CTRL_N;
  localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(GP_N);

  logic [7:0] ram [GP_N];
  logic [7:0] creg [CTRL_N];
  logic [8*CTRL_N-1:0] creg_flat;
  logic [7:0] ram_q, ctrl_q;
  logic sel_ctrl_q, wr_ctrl, rd_ctrl;

  assign wr_ctrl = (wr_addr >= CTRL_BASE);
  assign rd_ctrl = (rd_addr >= CTRL_BASE);

  for (genvar g = 0; g < CTRL_N; g++) begin : g_flat
    assign creg_flat[8*g +: 8] = creg[g];
  end

  // general-purpose area: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !wr_ctrl) ram[wr_addr] <= wr_data;
    if (rd_en) ram_q <= ram[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CTRL_N; i++) creg[i] <= ctrl_reset(CTRL_W'(i));
      ctrl_q <= '0;
      sel_ctrl_q <= 1'b0;
    end else begin
      if (wr_en && wr_ctrl)
        creg[wr_addr[CTRL_W-1:0]] <= wr_data & ctrl_mask(wr_addr[CTRL_W-1:0]);
      if (rd_en) begin
        sel_ctrl_q <= rd_ctrl;
        ctrl_q <= creg[rd_addr[CTRL_W-1:0]] & ctrl_mask(rd_addr[CTRL_W-1:0]);
      end
    end
  end

  assign rd_data  = sel_ctrl_q ? ctrl_q : ram_q;
  assign dac_code = {creg[0], creg[1][7:4]};

  assert_rsvd_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ctrl && ctrl_mask(wr_addr[CTRL_W-1:0]) == 8'h00) |=> $stable(creg_flat));
  assert_rsvd_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == CTRL_BASE + ADDR_W'(1)) |=> rd_data[3:0] == 4'h0);
  assert_dac_hi_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_BASE) |=> dac_code[DAC_W-1:4] == $past(wr_data));
endmodule

// File: rtl/spi_regmem.sv
module spi_regmem
  import spi_regmem_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  input  logic             shift_en_n,
  output logic             sdo,
  output logic [DAC_W-1:0] dac_code
);
  logic cs_fall, cs_rise, byte_done, tx_load, rd_en, wr_en;
  logic [7:0] rx_byte, tx_byte, rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  spi_regmem_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .shift_en_n(shift_en_n),
    .tx_load(tx_load), .tx_byte(tx_byte), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .byte_done(byte_done), .rx_byte(rx_byte), .sdo(sdo));

  spi_regmem_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_data(rd_data), .tx_load(tx_load), .tx_byte(tx_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  spi_regmem_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dac_code(dac_code));
endmodule

// File: tb/sim_spi_regmem.sv
module sim_spi_regmem;
  localparam int H = 6;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, shift_en_n = 1'b0;
  logic sdo;
  logic [11:0] dac_code;
  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [64];
  logic [7:0] wdat [16];

  always #10 clk = ~clk;

  spi_regmem u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
                 .shift_en_n(shift_en_n), .sdo(sdo), .dac_code(dac_code));

  function automatic logic [7:0] mask_of(input logic [5:0] a);
    if (a < 6'd56) return 8'hFF;
    case (a)
      6'h38, 6'h3C: return 8'hFF;
      6'h39, 6'h3D: return 8'hF0;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic logic [11:0] exp_dac();
    return {model[56], model[57][7:4]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      sdi = tx[i];
      wait_clk(H);
      rx[i] = sdo;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic begin_cs();
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic end_cs();
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4 * H);
  endtask

  task automatic wr_burst(input logic [5:0] a, input int n);
    logic [7:0] r;
    logic [5:0] t;
    begin_cs();
    xfer(8'h02, 8, r);
    xfer({2'b00, a}, 8, r);
    for (int k = 0; k < n; k++) begin
      xfer(wdat[k], 8, r);
      t = {a[5:3], 3'(a[2:0] + 3'(k))};
      model[t] = wdat[k] & mask_of(t);
    end
    end_cs();
  endtask

  task automatic rd_burst(input logic [5:0] a, input int n, input string req);
    logic [7:0] r;
    begin_cs();
    xfer(8'h03, 8, r);
    xfer({2'b00, a}, 8, r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r);
      check(req, r, model[6'(a + 6'(k))]);
    end
    end_cs();
  endtask

  initial begin
    logic [7:0] r;
    logic [5:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    model[6'h3C] = 8'h84;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1 reset state
    check("R1 sdo after reset", sdo, 0);
    check("R1 dac_code after reset", dac_code, 12'h000);
    rd_burst(6'h38, 8, "R1 control defaults");
    check("R3 sdo idle with cs high", sdo, 0);

    // R6 fill every general-purpose page
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < 8; k++) wdat[k] = 8'($urandom);
      wr_burst(6'(p * 8), 8);
    end
    // R5 long read passing the top wrap
    rd_burst(6'h2D, 70, "R5 incrementing read with wrap");

    // R6 page wrap with overwrite
    for (int k = 0; k < 10; k++) wdat[k] = 8'($urandom);
    wr_burst(6'h0E, 10);
    rd_burst(6'h08, 8, "R6 page wrap write");

    // R8 R9 control page all ones
    for (int k = 0; k < 8; k++) wdat[k] = 8'hFF;
    wr_burst(6'h38, 8);
    rd_burst(6'h38, 8, "R8 R9 reserved masking");
    check("R10 full scale code", dac_code, 12'hFFF);
    wdat[0] = 8'h00; wdat[1] = 8'h00;
    wr_burst(6'h38, 2);
    check("R10 zero scale code", dac_code, 12'h000);
    for (int j = 0; j < 3; j++) begin
      wdat[0] = 8'($urandom); wdat[1] = 8'($urandom);
      wr_burst(6'h38, 2);
      check("R10 random code", dac_code, exp_dac());
    end

    // R7 partial last byte dropped
    begin_cs();
    xfer(8'h02, 8, r);
    xfer(8'h10, 8, r);
    xfer(8'h5A, 8, r);
    xfer(8'hC3, 5, r);
    end_cs();
    model[6'h10] = 8'h5A;
    rd_burst(6'h10, 2, "R7 partial byte discarded");

    // R4 unknown opcode ignored
    begin_cs();
    xfer(8'h05, 8, r);
    xfer(8'h20, 8, r);
    xfer(8'hA5, 8, r);
    check("R4 sdo quiet on bad opcode", r, 8'h00);
    end_cs();
    rd_burst(6'h20, 1, "R4 bad opcode writes nothing");
    // R4 upper address bits ignored
    wdat[0] = 8'h3C;
    wr_burst(6'h03, 1);
    begin_cs();
    xfer(8'h03, 8, r);
    xfer(8'hC3, 8, r);
    xfer(8'h00, 8, r);
    check("R4 address upper bits ignored", r, 8'h3C);
    end_cs();

    // R2 stalled shifting
    begin_cs();
    xfer(8'h02, 8, r);
    xfer(8'h28, 8, r);
    xfer(8'h96, 4, r);
    shift_en_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sdi = 1'b1;
      wait_clk(H); sck = 1'b1; wait_clk(H); sck = 1'b0;
    end
    shift_en_n = 1'b0;
    xfer(8'h60, 4, r);
    end_cs();
    model[6'h28] = 8'h96;
    rd_burst(6'h28, 1, "R2 shift enable gating");
    check("R3 sdo idle after read", sdo, 0);

    // random mixed traffic
    for (int j = 0; j < 24; j++) begin
      a = 6'($urandom);
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < 10; k++) wdat[k] = 8'($urandom);
        wr_burst(a, 1 + int'($urandom % 10));
        check("R10 code after random write", dac_code, exp_dac());
      end else begin
        rd_burst(a, 1 + int'($urandom % 12), "R5 R6 random read");
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule